// File: doc/BRIEF.md
# Size-Aware Condition Flag Evaluator

This block derives the condition flags of an operation from the operands and the result that the ALU has already produced. From the source, the destination, the result, the operand size and the operation class, it computes negative (N), zero (Z), overflow (V) and carry (C). It also computes a separate R flag for the multiply-carry class. For multiplies it uses an extra high result word. Carry and overflow are inferred from the top bits of the sized operands and result, not from an adder carry chain. The block can therefore sit off the datapath and evaluate flags lazily, some cycles after the arithmetic was done.

The computed flags are merged into a status word under a write mask. The extended-arithmetic flag X, read from the incoming status, makes Z sticky: a chained multi-word operation can clear Z but never set it. Every update clears X. The merged word is captured in an output register when the update strobe is high.

Top module: `flag_eval_unit`

## Requirements
- R1: For add-type classes (code 0, the multiply-carry class 7, and unused codes 9 to 15) with the sized result MSB set, N=1 and Z=0. V=1 only when both sized operand MSBs are 0, and C=1 only when both are 1.
- R2: For add-type classes with the sized result MSB clear, N=0. Z=1 exactly when the result is zero within the size, V=1 when both operand MSBs are 1, and C=1 when either operand MSB is 1.
- R3: Size code 0 uses bit 7 and the low 8 bits, code 1 uses bit 15 and the low 16 bits, and code 2 uses bit 31 and all 32 bits. Code 3 yields no computed flags, except that the subtract classes still invert C, which gives C=1.
- R4: Subtract (code 1) and compare (code 2) invert the source before evaluation with the add rules, and invert the resulting C.
- R5: Move (code 3) and logic/shift (code 4) produce only N and Z: N from the sized result MSB, and otherwise Z when the sized result is zero. V and C are computed as 0.
- R6: Unsigned multiply (code 5) forms {hi, res} as 64 bits. Z=1 when all 64 bits are zero, N is bit 63, and V=1 when hi is nonzero.
- R7: Signed multiply (code 6) uses the same N and Z as R6, and sets V when hi differs from 32 copies of res bit 31.
- R8: The multiply-carry class (code 7) follows R1 and R2, but puts the carry value into R (status bit 8) and computes C as 0.
- R9: Status bits 0 to 4 and 8 hold C, V, Z, N, X and R. Every status bit set in wr_mask, plus the X bit, takes the computed value; all other bits keep stat_in. X therefore ends at 0.
- R10: When stat_in has X set and the computed Z is 1, the Z bit keeps its stat_in value. With X set, Z can be cleared but never set.
- R11: The pass-through class (code 8) copies stat_in unchanged, including X.
- R12: stat_q resets to zero, loads the merged status on a clock edge with upd_en high, and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_en | input | 1 | Load strobe for the status register |
| op_cls | input | 4 | Operation class code |
| op_size | input | 2 | Operand size code |
| src | input | 32 | Source operand |
| dst | input | 32 | Destination operand |
| res | input | 32 | Operation result (low word for multiplies) |
| hi | input | 32 | High result word of multiplies |
| stat_in | input | 32 | Current status word |
| wr_mask | input | 32 | Status bits the operation may write |
| stat_q | output | 32 | Registered new status |

## Verification
The hardest case to reach is the sticky-Z interplay. It needs X set in the incoming status, a computed Z of 1, and Z inside the write mask, all at once. The stored Z must then keep its old value rather than follow the computation. Random values seldom give a sized-zero result, so the stimulus forces the result to zero in its active bytes (with random upper bits) in a quarter of the cases. It also biases the high word toward the two sign-extension patterns, and adds directed cases with X set and the old Z both 0 and 1.

// File: rtl/flag_eval_pkg.sv
package flag_eval_pkg;

    typedef enum logic [3:0] {
        OPC_ADD   = 4'd0,
        OPC_SUB   = 4'd1,
        OPC_CMP   = 4'd2,
        OPC_MOVE  = 4'd3,
        OPC_LOGIC = 4'd4,
        OPC_MULU  = 4'd5,
        OPC_MULS  = 4'd6,
        OPC_MCP   = 4'd7,
        OPC_LIVE  = 4'd8
    } op_cls_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_NONE = 2'd3
    } op_size_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
        logic r;
    } flag_set_t;

    localparam flag_set_t FLAGS_NONE = '0;

endpackage

// File: rtl/fe_size_view.sv
module fe_size_view
    import flag_eval_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [1:0]        size,
    input  logic [DATA_W-1:0] value,
    output logic              msb,
    output logic              zero,
    output logic              valid
);
    localparam int BYTE_MSB = 7;
    localparam int HALF_MSB = 15;
    localparam int WORD_MSB = DATA_W - 1;

    always_comb begin
        msb   = 1'b0;
        zero  = 1'b0;
        valid = 1'b0;
        case (op_size_e'(size))
            SZ_BYTE: begin
                msb   = value[BYTE_MSB];
                zero  = (value[BYTE_MSB:0] == '0);
                valid = 1'b1;
            end
            SZ_HALF: begin
                msb   = value[HALF_MSB];
                zero  = (value[HALF_MSB:0] == '0);
                valid = 1'b1;
            end
            SZ_WORD: begin
                msb   = value[WORD_MSB];
                zero  = (value == '0);
                valid = 1'b1;
            end
            default: begin
                msb   = 1'b0;
                zero  = 1'b0;
                valid = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/fe_arith_flags.sv
module fe_arith_flags
    import flag_eval_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [1:0]        size,
    input  logic [DATA_W-1:0] src,
    input  logic [DATA_W-1:0] dst,
    input  logic [DATA_W-1:0] res,
    input  logic              inv_src,
    input  logic              inv_c,
    input  logic              c_to_r,
    output flag_set_t         flags
);
    localparam int N_VIEW  = 3;
    localparam int V_SRC   = 0;
    localparam int V_DST   = 1;
    localparam int V_RES   = 2;

    logic [N_VIEW-1:0][DATA_W-1:0] opnd;
    logic [N_VIEW-1:0]             v_msb;
    logic [N_VIEW-1:0]             v_zero;
    logic [N_VIEW-1:0]             v_ok;

    assign opnd[V_SRC] = inv_src ? ~src : src;
    assign opnd[V_DST] = dst;
    assign opnd[V_RES] = res;

    for (genvar g = 0; g < N_VIEW; g++) begin : g_view
        fe_size_view #(.DATA_W(DATA_W)) u_view (
            .size  (size),
            .value (opnd[g]),
            .msb   (v_msb[g]),
            .zero  (v_zero[g]),
            .valid (v_ok[g])
        );
    end

    always_comb begin
        logic sm;
        logic dm;
        flag_set_t f;
        f  = FLAGS_NONE;
        sm = v_msb[V_SRC];
        dm = v_msb[V_DST];
        if (v_ok[V_RES]) begin
            if (v_msb[V_RES]) begin
                f.n = 1'b1;
                if (!sm && !dm) begin
                    f.v = 1'b1;
                end else if (sm && dm) begin
                    f.c = 1'b1;
                end
            end else begin
                f.z = v_zero[V_RES];
                f.v = sm & dm;
                f.c = sm | dm;
            end
        end
        if (inv_c) begin
            f.c = ~f.c;
        end
        if (c_to_r) begin
            f.r = f.c;
            f.c = 1'b0;
        end
        flags = f;
    end

    logic unused_zero;
    assign unused_zero = ^{v_zero[V_SRC], v_zero[V_DST], v_ok[V_SRC], v_ok[V_DST]};

endmodule

// File: rtl/fe_mul_flags.sv
module fe_mul_flags
    import flag_eval_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              signed_mode,
    input  logic [DATA_W-1:0] res,
    input  logic [DATA_W-1:0] hi,
    output flag_set_t         flags
);
    localparam int FULL_W = 2 * DATA_W;

    logic [FULL_W-1:0] full;
    logic [DATA_W-1:0] sign_ext;

    assign full     = {hi, res};
    assign sign_ext = {DATA_W{res[DATA_W-1]}};

    always_comb begin
        flags   = FLAGS_NONE;
        flags.z = (full == '0);
        flags.n = full[FULL_W-1];
        if (signed_mode) begin
            flags.v = (hi != sign_ext);
        end else begin
            flags.v = (hi != '0);
        end
    end

endmodule

// File: rtl/fe_status_merge.sv
module fe_status_merge
    import flag_eval_pkg::*;
#(
    parameter int STATUS_W = 32,
    parameter int C_BIT    = 0,
    parameter int V_BIT    = 1,
    parameter int Z_BIT    = 2,
    parameter int N_BIT    = 3,
    parameter int X_BIT    = 4,
    parameter int R_BIT    = 8
) (
    input  logic [STATUS_W-1:0] old_stat,
    input  logic [STATUS_W-1:0] wr_mask,
    input  flag_set_t           flags,
    input  logic                pass,
    output logic [STATUS_W-1:0] new_stat
);
    localparam logic [STATUS_W-1:0] ONE = STATUS_W'(1);

    logic [STATUS_W-1:0] fvec;
    logic [STATUS_W-1:0] eff_mask;

    always_comb begin
        fvec = '0;
        fvec[C_BIT] = flags.c;
        fvec[V_BIT] = flags.v;
        fvec[Z_BIT] = flags.z;
        fvec[N_BIT] = flags.n;
        fvec[R_BIT] = flags.r;

        eff_mask = wr_mask | (ONE << X_BIT);
        if (old_stat[X_BIT] && flags.z) begin
            eff_mask[Z_BIT] = 1'b0;
        end

        if (pass) begin
            new_stat = old_stat;
        end else begin
            new_stat = (old_stat & ~eff_mask) | (fvec & eff_mask);
        end
    end

endmodule

// File: rtl/flag_eval_unit.sv
module flag_eval_unit
    import flag_eval_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int STATUS_W = 32,
    parameter int C_BIT    = 0,
    parameter int V_BIT    = 1,
    parameter int Z_BIT    = 2,
    parameter int N_BIT    = 3,
    parameter int X_BIT    = 4,
    parameter int R_BIT    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                upd_en,
    input  logic [3:0]          op_cls,
    input  logic [1:0]          op_size,
    input  logic [DATA_W-1:0]   src,
    input  logic [DATA_W-1:0]   dst,
    input  logic [DATA_W-1:0]   res,
    input  logic [DATA_W-1:0]   hi,
    input  logic [STATUS_W-1:0] stat_in,
    input  logic [STATUS_W-1:0] wr_mask,
    output logic [STATUS_W-1:0] stat_q
);
    typedef struct packed {
        logic [STATUS_W-1:0] stat;
    } state_t;

    op_cls_e   opc;
    logic      is_sub;
    logic      is_mcp;
    logic      is_live;
    flag_set_t arith_f;
    flag_set_t mul_f;
    flag_set_t move_f;
    flag_set_t sel_f;
    logic      mv_msb;
    logic      mv_zero;
    logic      mv_ok;
    logic [STATUS_W-1:0] merged;
    state_t    state_d;
    state_t    state_q;

    assign opc     = op_cls_e'(op_cls);
    assign is_sub  = (opc == OPC_SUB) || (opc == OPC_CMP);
    assign is_mcp  = (opc == OPC_MCP);
    assign is_live = (opc == OPC_LIVE);

    fe_arith_flags #(.DATA_W(DATA_W)) u_arith (
        .size    (op_size),
        .src     (src),
        .dst     (dst),
        .res     (res),
        .inv_src (is_sub),
        .inv_c   (is_sub),
        .c_to_r  (is_mcp),
        .flags   (arith_f)
    );

    fe_mul_flags #(.DATA_W(DATA_W)) u_mul (
        .signed_mode (opc == OPC_MULS),
        .res         (res),
        .hi          (hi),
        .flags       (mul_f)
    );

    fe_size_view #(.DATA_W(DATA_W)) u_move_view (
        .size  (op_size),
        .value (res),
        .msb   (mv_msb),
        .zero  (mv_zero),
        .valid (mv_ok)
    );

    always_comb begin
        move_f   = FLAGS_NONE;
        move_f.n = mv_ok & mv_msb;
        move_f.z = mv_ok & ~mv_msb & mv_zero;
    end

    fe_status_merge #(
        .STATUS_W (STATUS_W),
        .C_BIT    (C_BIT),
        .V_BIT    (V_BIT),
        .Z_BIT    (Z_BIT),
        .N_BIT    (N_BIT),
        .X_BIT    (X_BIT),
        .R_BIT    (R_BIT)
    ) u_merge (
        .old_stat (stat_in),
        .wr_mask  (wr_mask),
        .flags    (sel_f),
        .pass     (is_live),
        .new_stat (merged)
    );

    always_comb begin
        case (opc)
            OPC_MOVE, OPC_LOGIC: sel_f = move_f;
            OPC_MULU, OPC_MULS:  sel_f = mul_f;
            OPC_LIVE:            sel_f = FLAGS_NONE;
            default:             sel_f = arith_f;
        endcase

        state_d = state_q;
        if (upd_en) begin
            state_d.stat = merged;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign stat_q = state_q.stat;

endmodule

// File: rtl/flag_eval_unit_chk.sv
module flag_eval_unit_chk #(
    parameter int STATUS_W = 32,
    parameter int V_BIT    = 1,
    parameter int Z_BIT    = 2,
    parameter int X_BIT    = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                upd_en,
    input logic [3:0]          op_cls,
    input logic [31:0]         hi,
    input logic [STATUS_W-1:0] stat_in,
    input logic [STATUS_W-1:0] wr_mask,
    input logic [STATUS_W-1:0] stat_q
);
    localparam logic [STATUS_W-1:0] X_ONE = STATUS_W'(1) << X_BIT;
    localparam logic [3:0] LIVE_CODE = 4'd8;
    localparam logic [3:0] MULU_CODE = 4'd5;

    // R12
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_en |=> $stable(stat_q));

    // R9
    x_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && op_cls != LIVE_CODE) |=> !stat_q[X_BIT]);

    // R9
    unmasked_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && op_cls != LIVE_CODE) |=>
        (((stat_q ^ $past(stat_in)) & ~($past(wr_mask) | X_ONE)) == '0));

    // R10
    z_never_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && op_cls != LIVE_CODE && stat_in[X_BIT] && !stat_in[Z_BIT])
        |=> !stat_q[Z_BIT]);

    // R11
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && op_cls == LIVE_CODE) |=> (stat_q == $past(stat_in)));

    // R6
    mulu_high_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && op_cls == MULU_CODE && wr_mask[V_BIT] && hi != '0)
        |=> stat_q[V_BIT]);

endmodule

bind flag_eval_unit flag_eval_unit_chk #(
    .STATUS_W (STATUS_W),
    .V_BIT    (V_BIT),
    .Z_BIT    (Z_BIT),
    .X_BIT    (X_BIT)
) u_flag_eval_unit_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd_en  (upd_en),
    .op_cls  (op_cls),
    .hi      (hi),
    .stat_in (stat_in),
    .wr_mask (wr_mask),
    .stat_q  (stat_q)
);

// File: tb/test_flag_eval_unit.sv
module test_flag_eval_unit;
    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 3000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        upd_en = 1'b0;
    logic [3:0]  op_cls = '0;
    logic [1:0]  op_size = '0;
    logic [31:0] src = '0, dst = '0, res = '0, hi = '0;
    logic [31:0] stat_in = '0, wr_mask = '0;
    logic [31:0] stat_q;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flag_eval_unit i_flag_eval_unit (
        .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .op_cls(op_cls),
        .op_size(op_size), .src(src), .dst(dst), .res(res), .hi(hi),
        .stat_in(stat_in), .wr_mask(wr_mask), .stat_q(stat_q)
    );

    function automatic logic pick_msb(input logic [31:0] v, input logic [1:0] sz);
        case (sz)
            2'd0: return v[7];
            2'd1: return v[15];
            default: return v[31];
        endcase
    endfunction

    function automatic logic pick_zero(input logic [31:0] v, input logic [1:0] sz);
        case (sz)
            2'd0: return v[7:0] == 8'h0;
            2'd1: return v[15:0] == 16'h0;
            default: return v == 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] model(input logic [3:0] op, input logic [1:0] sz,
        input logic [31:0] s, input logic [31:0] d, input logic [31:0] r,
        input logic [31:0] h, input logic [31:0] old, input logic [31:0] msk);
        logic n, z, v, c, rf, sm, dm, rm, ok, sub;
        logic [63:0] w;
        logic [31:0] m, fv;
        n = 0; z = 0; v = 0; c = 0; rf = 0;
        if (op == 4'd8) return old;
        ok  = (sz != 2'd3);
        sub = (op == 4'd1) || (op == 4'd2);
        rm  = pick_msb(r, sz);
        if (op == 4'd3 || op == 4'd4) begin
            if (ok) begin
                n = rm;
                z = !rm && pick_zero(r, sz);
            end
        end else if (op == 4'd5 || op == 4'd6) begin
            w = {h, r};
            z = (w == 64'h0);
            n = w[63];
            v = (op == 4'd6) ? (h != {32{r[31]}}) : (h != 32'h0);
        end else begin
            sm = pick_msb(sub ? ~s : s, sz);
            dm = pick_msb(d, sz);
            if (ok) begin
                if (rm) begin
                    n = 1;
                    if (!sm && !dm) v = 1;
                    else if (sm && dm) c = 1;
                end else begin
                    z = pick_zero(r, sz);
                    v = sm & dm;
                    c = sm | dm;
                end
            end
            if (sub) c = !c;
            if (op == 4'd7) begin
                rf = c;
                c  = 0;
            end
        end
        m = msk | 32'h10;
        if (old[4] && z) m[2] = 1'b0;
        fv = {23'b0, rf, 4'b0, n, z, v, c};
        return (old & ~m) | (fv & m);
    endfunction

    function automatic string tag_of(input logic [3:0] op, input logic [1:0] sz);
        if (sz == 2'd3 && op != 4'd8 && !(op == 4'd5 || op == 4'd6)) return "R3";
        case (op)
            4'd1, 4'd2: return "R4";
            4'd3, 4'd4: return "R5";
            4'd5: return "R6";
            4'd6: return "R7";
            4'd7: return "R8";
            4'd8: return "R11";
            default: return "R1 R2";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: stat_q=%08h expected %08h (op=%0d size=%0d src=%08h dst=%08h res=%08h hi=%08h in=%08h mask=%08h)",
                     req, got, exp, op_cls, op_size, src, dst, res, hi, stat_in, wr_mask);
        end
    endtask

    task automatic apply(input logic [3:0] op, input logic [1:0] sz,
        input logic [31:0] s, input logic [31:0] d, input logic [31:0] r,
        input logic [31:0] h, input logic [31:0] old, input logic [31:0] msk,
        input string req);
        logic [31:0] exp;
        @(negedge clk);
        upd_en = 1'b1; op_cls = op; op_size = sz;
        src = s; dst = d; res = r; hi = h; stat_in = old; wr_mask = msk;
        exp = model(op, sz, s, d, r, h, old, msk);
        @(posedge clk);
        #1;
        check(req, stat_q, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] prev;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(posedge clk);
        #1;
        check("R12 reset", stat_q, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: byte add, result MSB set, both operand MSBs clear -> N,V
        apply(4'd0, 2'd0, 32'h0000_0040, 32'h0000_0040, 32'hFFFF_FF80, 0, 0, 32'hFFFF_FFFF, "R1");
        check("R1 nv", stat_q, 32'h0000_000A);
        // R2: half add, sized-zero result with upper garbage, both MSBs set -> Z,V,C
        apply(4'd0, 2'd1, 32'h0000_8000, 32'h0000_8000, 32'h0001_0000, 0, 0, 32'h1F, "R2 R3");
        check("R2 zvc", stat_q, 32'h0000_0007);
        // R4: word compare equal -> Z and C inverted to 0
        apply(4'd2, 2'd2, 32'h1234_5678, 32'h1234_5678, 32'h0, 0, 0, 32'h1F, "R4");
        check("R4 eq", stat_q, 32'h0000_0004);
        // R3: size code 3 subtract -> only C set
        apply(4'd1, 2'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 0, 32'h0, 32'h1F, "R3");
        check("R3 none", stat_q, 32'h0000_0001);
        // R5: move half negative
        apply(4'd3, 2'd1, 0, 0, 32'h0000_8000, 0, 32'h0000_0003, 32'h0F, "R5");
        check("R5 n", stat_q, 32'h0000_0008);
        // R6: unsigned multiply high nonzero
        apply(4'd5, 2'd2, 0, 0, 32'h0, 32'h8000_0000, 0, 32'h0F, "R6");
        check("R6 nv", stat_q, 32'h0000_000A);
        // R7: signed multiply proper sign extension -> no V
        apply(4'd6, 2'd2, 0, 0, 32'h8000_0000, 32'hFFFF_FFFF, 0, 32'h0F, "R7");
        check("R7 ext", stat_q, 32'h0000_0008);
        apply(4'd6, 2'd2, 0, 0, 32'h8000_0000, 32'h0, 0, 32'h0F, "R7");
        check("R7 ovf", stat_q, 32'h0000_0002);
        // R8: multiply-carry with carry -> R bit 8
        apply(4'd7, 2'd2, 32'h8000_0000, 32'h8000_0000, 32'h0000_0001, 0, 0, 32'h10F, "R8");
        check("R8 r", stat_q, 32'h0000_0102);
        // R10: X set, old Z clear, zero result -> Z stays 0, X cleared
        apply(4'd3, 2'd2, 0, 0, 32'h0, 0, 32'h0000_0010, 32'h0F, "R10");
        check("R10 sticky", stat_q, 32'h0000_0000);
        // R10: X set, old Z set, nonzero result -> Z cleared
        apply(4'd3, 2'd2, 0, 0, 32'h5, 0, 32'h0000_0014, 32'h0F, "R10");
        check("R10 clr", stat_q, 32'h0000_0000);
        // R9: unmasked bits keep old value
        apply(4'd0, 2'd2, 0, 0, 32'h8000_0000, 0, 32'hA5A5_A5FF, 32'h0000_0008, "R9");
        check("R9 keep", stat_q, 32'hA5A5_A5EF);
        // R11: pass-through keeps X
        apply(4'd8, 2'd2, 0, 0, 0, 0, 32'hDEAD_BEEF, 32'hFFFF_FFFF, "R11");
        check("R11 pass", stat_q, 32'hDEAD_BEEF);

        // R12: hold when upd_en low
        prev = stat_q;
        @(negedge clk);
        upd_en = 1'b0; op_cls = 4'd0; stat_in = 32'h0; wr_mask = 32'hFFFF_FFFF; res = 32'h0;
        @(posedge clk);
        #1;
        check("R12 hold", stat_q, prev);

        for (int i = 0; i < N_RANDOM; i++) begin
            logic [3:0] op;
            logic [1:0] sz;
            logic [31:0] r, h;
            int k;
            op = ($urandom % 4 == 0) ? 4'($urandom % 16) : 4'($urandom % 9);
            sz = 2'($urandom % 4);
            r  = $urandom;
            k  = $urandom % 4;
            if (k == 0) begin
                case (sz)
                    2'd0: r[7:0] = 8'h0;
                    2'd1: r[15:0] = 16'h0;
                    default: r = 32'h0;
                endcase
            end
            case ($urandom % 3)
                0: h = 32'h0;
                1: h = 32'hFFFF_FFFF;
                default: h = $urandom;
            endcase
            apply(op, sz, $urandom, $urandom, r, h, $urandom, $urandom, tag_of(op, sz));
        end

        // R12: reset mid-run clears the register
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R12 reset again", stat_q, 32'h0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule